// File: doc/BRIEF.md
# Two-Wire Serial Byte-Store Slave with Paged, Self-Timed Writes

This block is a two-wire bus slave in front of a byte-wide storage array. The word address is 15 bits wide. The bus lines reach it already filtered. It samples them with the system clock and detects start and stop conditions and clock edges. It pulls the data line low through an open-drain enable, so the line is either driven low or left released. Two strap inputs select one of four bus addresses. A write-protect input blocks every change to the array.

A write has five parts in order: a select byte, two address bytes, one or more data bytes, and a stop. The data bytes first go into a one-page buffer of 64 bytes. Nothing reaches the array until the stop. The stop starts a self-timed busy period, and the buffered bytes are copied into the array during it. A master finds out when the write has finished by polling. While the busy period runs, the slave leaves its select byte unacknowledged.

Three kinds of read are supported: random reads (a dummy write that sets the address, then a repeated start), current-address reads and sequential reads. The storage depth is a parameter (`STORE_W` address bits). The word address stays 15 bits wide, and address bits above the storage depth alias.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: After reset, and after any stop, the slave leaves SDA released. A start at any point (SDA falling while SCL is high) abandons the current transfer, and the next 8 bits are taken as a select byte. A stop (SDA rising while SCL is high) returns the slave to idle.
- R2: The select byte, MSB first, is `1010`, then `0`, then strap bit 1, then strap bit 0, then the direction bit (1 = read). A matching byte is acknowledged: the slave drives SDA low for the whole ninth clock. A non-matching byte is not acknowledged, and the slave ignores all later bytes until the next start.
- R3: Incoming bits are captured on the rising edge of SCL, MSB first. Outgoing data changes only while SCL is low, after its falling edge.
- R4: A write sends the select byte, then the address high byte, then the address low byte, then the data bytes, and each of these is acknowledged. Bits 6:0 of the high byte are address bits 14:8, and its bit 7 is ignored. Storage holds 2^STORE_W bytes, and higher address bits alias.
- R5: A stop that ends a write with at least one data byte starts a busy period of WR_CYCLES clocks (64 at least). During that period the buffered bytes are written to the array, and select bytes are not acknowledged.
- R6: During a write, the low 6 address bits step up by one after each data byte and wrap within the 64-byte page. A 65th byte therefore overwrites the first byte of the page.
- R7: A partial page write changes only the bytes that were loaded. Every other byte of that page keeps its value.
- R8: If the write-protect input is high at the stop, the array is left unchanged and no busy period starts.
- R9: A random read returns the byte at the address just loaded. The read is a write select, the two address bytes, a repeated start, and a read select.
- R10: A current-address read begins at the address that follows the last byte read or written. After a page write, this is the next offset within the same page.
- R11: A sequential read steps up through the full 15-bit address after each byte and wraps from 0x7FFF to 0x0000.
- R12: A master NACK after a read byte ends the read. The slave keeps SDA released until the next start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Filtered serial clock level |
| sda_i | input | 1 | Filtered serial data level (resolved bus) |
| strap_i | input | 2 | Bus address straps (bit 1, bit 0) |
| wp_i | input | 1 | Write protect, high blocks array writes |
| sda_oe_o | output | 1 | Open-drain enable, high pulls SDA low |

## Verification
Some properties are checked on every cycle. The data enable may change only while the synchronized clock is low. A start always puts the slave back at the select byte. A select byte that arrives during a busy period is left unacknowledged. A busy period begins only when a stop sees write protect low. The slave stays released while it ignores the bus. The bench scenarios cover what depends on data: wrap-around inside a page, partial page loads leaving the other bytes untouched, the address pointer after a write and after a read, the 15-bit wrap during a sequential read, and how polling sees the busy period.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_IGNORE
    } bus_state_e;

    typedef enum logic [1:0] {
        K_DEV,
        K_AHI,
        K_ALO,
        K_DATA
    } byte_kind_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_ev_t;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

    function automatic logic select_match(input logic [7:0] b, input logic [1:0] strap);
        return b[7:1] == {DEV_TYPE, 1'b0, strap};
    endfunction

endpackage

// File: rtl/i2c_line_mon.sv
module i2c_line_mon
    import eeprom_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);
    logic [1:0] scl_sy, sda_sy;
    logic       scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sy <= 2'b11;
            sda_sy <= 2'b11;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sy <= {scl_sy[0], scl_i};
            sda_sy <= {sda_sy[0], sda_i};
            scl_q  <= scl_sy[1];
            sda_q  <= sda_sy[1];
        end
    end

    always_comb begin
        ev.scl      = scl_sy[1];
        ev.sda      = sda_sy[1];
        ev.scl_rise = scl_sy[1] & ~scl_q;
        ev.scl_fall = ~scl_sy[1] & scl_q;
        ev.start    = scl_sy[1] & scl_q & sda_q & ~sda_sy[1];
        ev.stop     = scl_sy[1] & scl_q & ~sda_q & sda_sy[1];
    end

endmodule

// File: rtl/page_buffer.sv
module page_buffer #(
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              we,
    input  logic [PAGE_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [PAGE_W-1:0] raddr,
    output logic [7:0]        rdata,
    output logic              rvalid
);
    localparam int PAGE_BYTES = 1 << PAGE_W;

    logic [7:0]            bytes_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] loaded_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            loaded_q <= '0;
        end else if (clr) begin
            loaded_q <= '0;
        end else if (we) begin
            loaded_q[waddr] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            bytes_q[waddr] <= wdata;
        end
    end

    assign rdata  = bytes_q[raddr];
    assign rvalid = loaded_q[raddr];

    // R7
    clr_we_excl_chk: assert property (@(posedge clk) disable iff (rst) !(clr && we));

endmodule

// File: rtl/commit_timer.sv
module commit_timer #(
    parameter int PAGE_W    = 6,
    parameter int PG_W      = 5,
    parameter int WR_CYCLES = 5000
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   go,
    input  logic [PG_W-1:0]        page,
    input  logic                   buf_valid,
    output logic                   busy,
    output logic [PAGE_W-1:0]      buf_raddr,
    output logic                   mem_we,
    output logic [PG_W+PAGE_W-1:0] mem_waddr
);
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int RUN        = (WR_CYCLES > PAGE_BYTES) ? WR_CYCLES : PAGE_BYTES;
    localparam int CNT_W      = $clog2(RUN + 1);

    logic [CNT_W-1:0] cnt;
    logic [PG_W-1:0]  page_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            cnt    <= '0;
            page_q <= '0;
        end else if (!busy) begin
            if (go) begin
                busy   <= 1'b1;
                cnt    <= '0;
                page_q <= page;
            end
        end else if (cnt == CNT_W'(RUN - 1)) begin
            busy <= 1'b0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    assign buf_raddr = cnt[PAGE_W-1:0];
    assign mem_we    = busy && (cnt < CNT_W'(PAGE_BYTES)) && buf_valid;
    assign mem_waddr = {page_q, cnt[PAGE_W-1:0]};

    // R5
    no_go_busy_chk: assert property (@(posedge clk) disable iff (rst) busy |-> !go);

endmodule

// File: rtl/byte_array.sv
module byte_array #(
    parameter int STORE_W = 11
) (
    input  logic               clk,
    input  logic               we,
    input  logic [STORE_W-1:0] waddr,
    input  logic [7:0]         wdata,
    input  logic [STORE_W-1:0] raddr,
    output logic [7:0]         rdata
);
    localparam int DEPTH = 1 << STORE_W;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave
    import eeprom_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int PAGE_W    = 6,
    parameter int STORE_W   = 11,
    parameter int WR_CYCLES = 5000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] strap_i,
    input  logic       wp_i,
    output logic       sda_oe_o
);
    localparam int HI_W = ADDR_W - 8;
    localparam int PG_W = STORE_W - PAGE_W;

    line_ev_t          ev;
    bus_state_e        state;
    byte_kind_e        kind;
    logic [3:0]        bitcnt;
    logic [7:0]        shreg;
    logic [ADDR_W-1:0] addr;
    logic              rd_mode;
    logic              pending;
    logic              mack_ok;
    logic              sda_oe;

    logic              byte_done;
    logic              buf_clr, buf_we, go;
    logic [7:0]        rd_data;
    logic              busy;
    logic [PAGE_W-1:0] buf_raddr;
    logic [7:0]        buf_rdata;
    logic              buf_valid;
    logic              mem_we;
    logic [STORE_W-1:0] mem_waddr;

    i2c_line_mon u_line (
        .clk  (clk),
        .rst  (rst),
        .scl_i(scl_i),
        .sda_i(sda_i),
        .ev   (ev)
    );

    assign byte_done = (state == ST_RX) && ev.scl_fall && (bitcnt == 4'd8)
                       && !ev.start && !ev.stop;
    assign buf_clr   = byte_done && (kind == K_ALO);
    assign buf_we    = byte_done && (kind == K_DATA);
    assign go        = ev.stop && !ev.start && pending && !wp_i;

    page_buffer #(.PAGE_W(PAGE_W)) u_pbuf (
        .clk   (clk),
        .rst   (rst),
        .clr   (buf_clr),
        .we    (buf_we),
        .waddr (addr[PAGE_W-1:0]),
        .wdata (shreg),
        .raddr (buf_raddr),
        .rdata (buf_rdata),
        .rvalid(buf_valid)
    );

    commit_timer #(.PAGE_W(PAGE_W), .PG_W(PG_W), .WR_CYCLES(WR_CYCLES)) u_commit (
        .clk      (clk),
        .rst      (rst),
        .go       (go),
        .page     (addr[STORE_W-1:PAGE_W]),
        .buf_valid(buf_valid),
        .busy     (busy),
        .buf_raddr(buf_raddr),
        .mem_we   (mem_we),
        .mem_waddr(mem_waddr)
    );

    byte_array #(.STORE_W(STORE_W)) u_array (
        .clk  (clk),
        .we   (mem_we),
        .waddr(mem_waddr),
        .wdata(buf_rdata),
        .raddr(addr[STORE_W-1:0]),
        .rdata(rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            kind    <= K_DEV;
            bitcnt  <= '0;
            shreg   <= '0;
            addr    <= '0;
            rd_mode <= 1'b0;
            pending <= 1'b0;
            mack_ok <= 1'b0;
            sda_oe  <= 1'b0;
        end else if (ev.start) begin
            state   <= ST_RX;
            kind    <= K_DEV;
            bitcnt  <= '0;
            rd_mode <= 1'b0;
            pending <= 1'b0;
            sda_oe  <= 1'b0;
        end else if (ev.stop) begin
            state   <= ST_IDLE;
            pending <= 1'b0;
            sda_oe  <= 1'b0;
        end else begin
            unique case (state)
                ST_RX: begin
                    if (ev.scl_rise && bitcnt != 4'd8) begin
                        shreg  <= {shreg[6:0], ev.sda};
                        bitcnt <= bitcnt + 4'd1;
                    end
                    if (byte_done) begin
                        bitcnt <= '0;
                        unique case (kind)
                            K_DEV: begin
                                if (select_match(shreg, strap_i) && !busy) begin
                                    rd_mode <= shreg[0];
                                    if (!shreg[0]) kind <= K_AHI;
                                    state  <= ST_ACK;
                                    sda_oe <= 1'b1;
                                end else begin
                                    state <= ST_IGNORE;
                                end
                            end
                            K_AHI: begin
                                addr[ADDR_W-1:8] <= shreg[HI_W-1:0];
                                kind   <= K_ALO;
                                state  <= ST_ACK;
                                sda_oe <= 1'b1;
                            end
                            K_ALO: begin
                                addr[7:0] <= shreg;
                                kind   <= K_DATA;
                                state  <= ST_ACK;
                                sda_oe <= 1'b1;
                            end
                            K_DATA: begin
                                addr    <= {addr[ADDR_W-1:PAGE_W],
                                            addr[PAGE_W-1:0] + PAGE_W'(1)};
                                pending <= 1'b1;
                                state   <= ST_ACK;
                                sda_oe  <= 1'b1;
                            end
                            default: state <= ST_IGNORE;
                        endcase
                    end
                end
                ST_ACK: begin
                    if (ev.scl_fall) begin
                        if (rd_mode) begin
                            state  <= ST_TX;
                            shreg  <= rd_data;
                            sda_oe <= ~rd_data[7];
                            addr   <= addr + ADDR_W'(1);
                            bitcnt <= '0;
                        end else begin
                            state  <= ST_RX;
                            sda_oe <= 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (ev.scl_fall) begin
                        if (bitcnt == 4'd7) begin
                            sda_oe <= 1'b0;
                            state  <= ST_MACK;
                            bitcnt <= '0;
                        end else begin
                            shreg  <= {shreg[6:0], 1'b0};
                            sda_oe <= ~shreg[6];
                            bitcnt <= bitcnt + 4'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (ev.scl_rise) mack_ok <= ~ev.sda;
                    if (ev.scl_fall) begin
                        if (mack_ok) begin
                            state  <= ST_TX;
                            shreg  <= rd_data;
                            sda_oe <= ~rd_data[7];
                            addr   <= addr + ADDR_W'(1);
                            bitcnt <= '0;
                        end else begin
                            state <= ST_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign sda_oe_o = sda_oe;

    // R1
    start_entry_chk: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (state == ST_RX && bitcnt == 4'd0 && !sda_oe));

    // R3
    oe_low_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) |-> !ev.scl);

    // R2
    bitcnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        bitcnt <= 4'd8);

    // R5
    busy_nack_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_done && kind == K_DEV && busy) |=> (state == ST_IGNORE && !sda_oe));

    // R8
    wp_commit_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(!wp_i && ev.stop));

    // R12
    ignore_release_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IGNORE) |-> !sda_oe);

endmodule

// File: tb/test_eeprom_i2c_slave.sv
module test_eeprom_i2c_slave;

    localparam int P  = 6;
    localparam int WR = 600;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       wp = 1'b0;
    logic [1:0] strap = 2'b10;
    logic       oe;
    wire        sda_line = sda_m & ~oe;

    always #10 clk = ~clk;

    eeprom_i2c_slave #(.WR_CYCLES(WR)) i_eeprom_i2c_slave (
        .clk     (clk),
        .rst     (rst),
        .scl_i   (scl_m),
        .sda_i   (sda_line),
        .strap_i (strap),
        .wp_i    (wp),
        .sda_oe_o(oe)
    );

    logic [7:0] model [0:2047];
    int  nvec  = 0;
    int  nfail = 0;
    bit  done  = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 37 + i * 13 + 5) & 255);
    endfunction

    task automatic bus_start();
        sda_m = 1'b1; wt(P);
        scl_m = 1'b1; wt(P);
        sda_m = 1'b0; wt(P);
        scl_m = 1'b0; wt(P);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(P);
        scl_m = 1'b1; wt(P);
        sda_m = 1'b1; wt(2 * P);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wt(P);
            scl_m = 1'b1; wt(2 * P);
            scl_m = 1'b0; wt(P);
        end
        sda_m = 1'b1; wt(P);
        scl_m = 1'b1; wt(P);
        ack = !sda_line;
        wt(P);
        scl_m = 1'b0; wt(P);
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(2 * P);
            scl_m = 1'b1; wt(P);
            b[i] = sda_line;
            wt(P);
            scl_m = 1'b0;
        end
        wt(P);
        sda_m = mack ? 1'b0 : 1'b1; wt(P);
        scl_m = 1'b1; wt(2 * P);
        scl_m = 1'b0; wt(P);
        sda_m = 1'b1;
    endtask

    task automatic send_addr(input int a, input bit hi7, input string req);
        bit ack;
        send_byte({hi7, 7'(a >> 8)}, ack);
        check(ack, req, ack, 1);
        send_byte(8'(a), ack);
        check(ack, req, ack, 1);
    endtask

    task automatic write_seq(input int a, input int n, input int seed, input string req);
        bit ack;
        bus_start();
        send_byte({4'b1010, 1'b0, strap, 1'b0}, ack);
        check(ack, {req, " R2 select ack"}, ack, 1);
        send_addr(a, 1'b1, {req, " R4 address ack"});
        for (int i = 0; i < n; i++) begin
            int full;
            full = (a & 32'h7FC0) | ((a + i) & 63);
            send_byte(pat(seed, i), ack);
            check(ack, {req, " R4 data ack"}, ack, 1);
            if (!wp) model[full & 2047] = pat(seed, i);
        end
        bus_stop();
    endtask

    task automatic wait_ready(input bit expect_busy, input string req);
        bit ack;
        int polls = 0;
        bit ready = 0;
        while (!ready && polls < 20) begin
            bus_start();
            send_byte({4'b1010, 1'b0, strap, 1'b0}, ack);
            bus_stop();
            if (polls == 0) check(ack == !expect_busy, req, ack, !expect_busy);
            ready = ack;
            polls++;
        end
        check(ready, {req, " ready after busy"}, ready, 1);
    endtask

    task automatic read_rand(input int a, input int n, input string req);
        bit ack;
        logic [7:0] b;
        bus_start();
        send_byte({4'b1010, 1'b0, strap, 1'b0}, ack);
        check(ack, {req, " R9 select"}, ack, 1);
        send_addr(a, 1'b0, {req, " R9 address"});
        bus_start();
        send_byte({4'b1010, 1'b0, strap, 1'b1}, ack);
        check(ack, {req, " R9 read select"}, ack, 1);
        for (int i = 0; i < n; i++) begin
            int full;
            full = (a + i) & 32'h7FFF;
            recv_byte(i != n - 1, b);
            check(b === model[full & 2047], {req, " R3 read data"}, b, model[full & 2047]);
        end
        bus_stop();
    endtask

    task automatic read_cur(input int exp_addr, input string req);
        bit ack;
        logic [7:0] b;
        bus_start();
        send_byte({4'b1010, 1'b0, strap, 1'b1}, ack);
        check(ack, {req, " select"}, ack, 1);
        recv_byte(1'b0, b);
        check(b === model[exp_addr & 2047], req, b, model[exp_addr & 2047]);
        bus_stop();
    endtask

    task automatic t_reset();
        wt(5);
        check(oe == 1'b0 && sda_line == 1'b1, "R1 reset releases SDA", oe, 0);
    endtask

    task automatic t_bad_select();
        bit ack;
        bus_start();
        send_byte({4'b1010, 1'b0, 2'b01, 1'b0}, ack);
        check(!ack, "R2 mismatched strap not acked", ack, 0);
        send_byte(8'h12, ack);
        check(!ack, "R2 bus ignored after mismatch", ack, 0);
        bus_stop();
    endtask

    task automatic t_full_page();
        write_seq(32'h1240, 64, 1, "full page");
        wait_ready(1'b1, "R5 select nacked while busy");
        read_rand(32'h1240, 64, "R9 full page readback");
    endtask

    task automatic t_wrap_partial();
        write_seq(32'h1240 + 60, 8, 2, "wrap");
        wait_ready(1'b1, "R5 busy after wrap write");
        read_rand(32'h1240, 64, "R6 R7 page after wrap");
    endtask

    task automatic t_cur_addr();
        write_seq(32'h2A85, 3, 3, "current");
        wait_ready(1'b1, "R5 busy after short write");
        read_cur(32'h2A88, "R10 current after write");
        read_cur(32'h2A89, "R10 current after read");
    endtask

    task automatic t_protect();
        wp = 1'b1;
        write_seq(32'h1240, 4, 4, "protect");
        wait_ready(1'b0, "R8 no busy when protected");
        wp = 1'b0;
        read_rand(32'h1240, 4, "R8 protected bytes unchanged");
    endtask

    task automatic t_wrap15();
        write_seq(32'h7FFF, 1, 5, "top");
        wait_ready(1'b1, "R5 busy top write");
        write_seq(32'h0000, 2, 6, "bottom");
        wait_ready(1'b1, "R5 busy bottom write");
        read_rand(32'h7FFF, 3, "R11 wrap 7FFF to 0");
    endtask

    task automatic t_nack_end();
        bit ack;
        logic [7:0] b;
        bus_start();
        send_byte({4'b1010, 1'b0, strap, 1'b0}, ack);
        send_addr(32'h1241, 1'b0, "R12 address");
        bus_start();
        send_byte({4'b1010, 1'b0, strap, 1'b1}, ack);
        recv_byte(1'b0, b);
        check(b === model[32'h241], "R12 last byte", b, model[32'h241]);
        recv_byte(1'b0, b);
        check(b == 8'hFF, "R12 released after NACK", b, 8'hFF);
        bus_stop();
    endtask

    task automatic t_start_abort();
        sda_m = 1'b1;
        for (int i = 0; i < 3; i++) begin
            sda_m = i[0]; wt(P);
            scl_m = 1'b1; wt(2 * P);
            scl_m = 1'b0; wt(P);
        end
        read_rand(32'h1250, 2, "R1 start aborts partial byte");
    endtask

    initial begin
        rst = 1'b1;
        wt(5);
        rst = 1'b0;
        t_reset();
        t_bad_select();
        t_full_page();
        t_wrap_partial();
        t_cur_addr();
        t_protect();
        t_wrap15();
        t_nack_end();
        bus_start();
        t_start_abort();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            nvec++;
            nfail++;
            $display("FAIL watchdog (R1..all): actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

endmodule